// File: doc/BRIEF.md
# Reorder Buffer Head Retirement Unit

This unit sits at the oldest end of a reorder buffer. Every cycle it looks at a window of `WIDTH` consecutive head entries. Each entry carries a valid flag, a completed flag, a non-speculative flag and a sequence number. The unit reports how many of those entries retire this cycle. The reorder buffer uses that count to advance its head pointer in the same cycle, so the count is produced combinationally from the window.

A non-speculative instruction may only begin execution once it has become the oldest instruction in the machine. While such an entry sits at slot 0 without having completed, the unit retires nothing. It sends one pulse carrying that entry's sequence number back to the issue stages, which can then launch the instruction. The pulse is not repeated while the same entry keeps waiting. A non-speculative entry at any slot other than 0 ends the retirement scan before that slot, so at most one such instruction is handled in a cycle.

The unit also keeps a few registered values:
- the sequence number of the youngest instruction retired so far;
- a counter of cycles lost to a waiting non-speculative head;
- a counter of cycles in which the full retirement width was used.

Top module: `rob_commit_head`

## Requirements
- R1: `pop_cnt` equals, in the same cycle, the length of the run of retirable entries that starts at slot 0. It never exceeds `WIDTH`. Slot i carries sequence number bits `[i*SEQ_W +: SEQ_W]` of `head_seq`.
- R2: An entry is retirable only if its `head_valid` and `head_done` bits are both 1. The first slot that fails this ends the run, so completed younger entries behind it are not counted.
- R3: An entry whose `head_nonspec` bit is 1 in any slot other than 0 ends the run before that slot, even if it has completed.
- R4: A non-speculative entry in slot 0 that is valid and completed retires. Later slots may then retire under R2 and R3.
- R5: Suppose slot 0 is valid, non-speculative and not completed, `stall` is 0, and that sequence number has not been sent already under R6. Then on the next cycle `ns_issue_vld` is 1 for exactly one cycle, and `ns_issue_seq` carries slot 0's sequence number.
- R6: Once a sequence number has been sent under R5, it is not sent again while it stays waiting at slot 0. The record of the sent number is cleared on any cycle in which slot 0 retires.
- R7: While `stall` is 1, `pop_cnt` is 0, no issue pulse is started, and neither statistics counter advances.
- R8: On the cycle after `pop_cnt` is non-zero, `last_seq` holds the sequence number of the youngest retired slot (slot `pop_cnt-1`). Otherwise it holds its value.
- R9: `ns_wait_cnt` increments by one on the cycle after each cycle in which slot 0 is valid, non-speculative and not completed while `stall` is 0.
- R10: `full_cnt` increments by one on the cycle after each cycle in which `pop_cnt` equals `WIDTH`.
- R11: While `rst` is 1, and on the first cycle after it, all registered outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Blocks retirement and issue pulses this cycle |
| head_valid | input | WIDTH | Slot holds an instruction; bit 0 is the oldest |
| head_done | input | WIDTH | Slot instruction has completed execution |
| head_nonspec | input | WIDTH | Slot instruction must execute non-speculatively |
| head_seq | input | WIDTH*SEQ_W | Slot sequence numbers, slot i at `[i*SEQ_W +: SEQ_W]` |
| pop_cnt | output | $clog2(WIDTH+1) | Entries retired this cycle |
| ns_issue_vld | output | 1 | One-cycle permission pulse for a non-speculative head |
| ns_issue_seq | output | SEQ_W | Sequence number carried by the pulse |
| last_seq | output | SEQ_W | Youngest retired sequence number |
| ns_wait_cnt | output | CNT_W | Cycles stalled behind a non-speculative head |
| full_cnt | output | CNT_W | Cycles retiring the full width |

## Verification
The only memory that decides future behaviour is the record of which sequence number was last sent. If that record is wrong, the fault shows at the ports one cycle later in one of two ways:
- the issue pulse repeats while the same entry waits;
- an issue pulse is missing for a new head after a retirement.

Errors in the scan appear at once on `pop_cnt`, in the cycle where the input pattern occurs. A wrong count then carries into `last_seq` and `full_cnt` on the following cycle. Random windows that often keep the same head sequence number are used to exercise the repeat-suppression path.

// File: rtl/rch_pkg.sv
package rch_pkg;
  // Bits needed to hold a count from 0 to n inclusive.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rch_scan.sv
module rch_scan #(
  parameter int WIDTH = 4,
  parameter int SEQ_W = 16,
  parameter int PW    = 3
) (
  input  logic                   stall,
  input  logic [WIDTH-1:0]       valid,
  input  logic [WIDTH-1:0]       done,
  input  logic [WIDTH-1:0]       nonspec,
  input  logic [WIDTH*SEQ_W-1:0] seq,
  output logic [PW-1:0]          pop,
  output logic [SEQ_W-1:0]       youngest,
  output logic                   full
);
  logic [WIDTH-1:0] ok;

  // Per-slot eligibility; slot 0 admits a non-speculative entry.
  for (genvar i = 0; i < WIDTH; i++) begin : g_ok
    if (i == 0) begin : g_head
      assign ok[i] = valid[i] & done[i];
    end else begin : g_tail
      assign ok[i] = valid[i] & done[i] & ~nonspec[i];
    end
  end

  always_comb begin
    logic go;
    go       = ~stall;
    pop      = '0;
    youngest = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (go && ok[i]) begin
        pop      = pop + PW'(1);
        youngest = seq[i*SEQ_W +: SEQ_W];
      end else begin
        go = 1'b0;
      end
    end
  end

  assign full = (pop == PW'(WIDTH));
endmodule

// File: rtl/rch_nonspec.sv
module rch_nonspec #(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall,
  input  logic             v0,
  input  logic             d0,
  input  logic             ns0,
  input  logic [SEQ_W-1:0] seq0,
  input  logic             head_retired,
  output logic             waiting,
  output logic             issue_vld,
  output logic [SEQ_W-1:0] issue_seq
);
  logic             sent;
  logic [SEQ_W-1:0] sent_seq;
  logic             fire;

  assign waiting = ~stall & v0 & ns0 & ~d0;
  assign fire    = waiting & ~(sent & (sent_seq == seq0));

  always_ff @(posedge clk) begin
    if (rst) begin
      sent      <= 1'b0;
      sent_seq  <= '0;
      issue_vld <= 1'b0;
      issue_seq <= '0;
    end else begin
      issue_vld <= fire;
      if (fire) begin
        issue_seq <= seq0;
        sent      <= 1'b1;
        sent_seq  <= seq0;
      end else if (head_retired) begin
        sent <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rch_stats.sv
module rch_stats #(
  parameter int SEQ_W = 16,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ns_wait,
  input  logic             full,
  input  logic             any_pop,
  input  logic [SEQ_W-1:0] youngest,
  output logic [CNT_W-1:0] ns_wait_cnt,
  output logic [CNT_W-1:0] full_cnt,
  output logic [SEQ_W-1:0] last_seq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ns_wait_cnt <= '0;
      full_cnt    <= '0;
      last_seq    <= '0;
    end else begin
      if (ns_wait) ns_wait_cnt <= ns_wait_cnt + CNT_W'(1);
      if (full)    full_cnt    <= full_cnt + CNT_W'(1);
      if (any_pop) last_seq    <= youngest;
    end
  end
endmodule

// File: rtl/rob_commit_head.sv
module rob_commit_head #(
  parameter int WIDTH = 4,
  parameter int SEQ_W = 16,
  parameter int CNT_W = 32,
  localparam int PW   = rch_pkg::cnt_bits(WIDTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   stall,
  input  logic [WIDTH-1:0]       head_valid,
  input  logic [WIDTH-1:0]       head_done,
  input  logic [WIDTH-1:0]       head_nonspec,
  input  logic [WIDTH*SEQ_W-1:0] head_seq,
  output logic [PW-1:0]          pop_cnt,
  output logic                   ns_issue_vld,
  output logic [SEQ_W-1:0]       ns_issue_seq,
  output logic [SEQ_W-1:0]       last_seq,
  output logic [CNT_W-1:0]       ns_wait_cnt,
  output logic [CNT_W-1:0]       full_cnt
);
  logic [SEQ_W-1:0] youngest;
  logic             full;
  logic             ns_wait;

  rch_scan #(.WIDTH(WIDTH), .SEQ_W(SEQ_W), .PW(PW)) u_scan (
    .stall    (stall),
    .valid    (head_valid),
    .done     (head_done),
    .nonspec  (head_nonspec),
    .seq      (head_seq),
    .pop      (pop_cnt),
    .youngest (youngest),
    .full     (full)
  );

  rch_nonspec #(.SEQ_W(SEQ_W)) u_ns (
    .clk          (clk),
    .rst          (rst),
    .stall        (stall),
    .v0           (head_valid[0]),
    .d0           (head_done[0]),
    .ns0          (head_nonspec[0]),
    .seq0         (head_seq[SEQ_W-1:0]),
    .head_retired (pop_cnt != '0),
    .waiting      (ns_wait),
    .issue_vld    (ns_issue_vld),
    .issue_seq    (ns_issue_seq)
  );

  rch_stats #(.SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_stats (
    .clk         (clk),
    .rst         (rst),
    .ns_wait     (ns_wait),
    .full        (full),
    .any_pop     (pop_cnt != '0),
    .youngest    (youngest),
    .ns_wait_cnt (ns_wait_cnt),
    .full_cnt    (full_cnt),
    .last_seq    (last_seq)
  );
endmodule

// File: rtl/rch_checker.sv
module rch_checker #(
  parameter int WIDTH = 4,
  parameter int SEQ_W = 16,
  parameter int CNT_W = 32,
  parameter int PW    = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   stall,
  input logic [WIDTH-1:0]       head_valid,
  input logic [WIDTH-1:0]       head_done,
  input logic [WIDTH-1:0]       head_nonspec,
  input logic [WIDTH*SEQ_W-1:0] head_seq,
  input logic [PW-1:0]          pop_cnt,
  input logic                   ns_issue_vld,
  input logic [SEQ_W-1:0]       ns_issue_seq,
  input logic [SEQ_W-1:0]       last_seq,
  input logic [CNT_W-1:0]       ns_wait_cnt,
  input logic [CNT_W-1:0]       full_cnt
);
  p_pop_bound_r1: assert property (@(posedge clk) disable iff (rst)
    pop_cnt <= PW'(WIDTH));

  p_head_block_r2: assert property (@(posedge clk) disable iff (rst)
    !(head_valid[0] && head_done[0]) |-> pop_cnt == '0);

  p_stall_r7: assert property (@(posedge clk) disable iff (rst)
    stall |-> pop_cnt == '0);

  p_issue_cause_r5: assert property (@(posedge clk) disable iff (rst)
    ns_issue_vld |-> ($past(head_valid[0] & head_nonspec[0] & ~head_done[0] & ~stall)
                      && ns_issue_seq == $past(head_seq[SEQ_W-1:0])));

  p_no_repeat_r6: assert property (@(posedge clk) disable iff (rst)
    (ns_issue_vld && head_seq[SEQ_W-1:0] == ns_issue_seq && pop_cnt == '0)
      |=> !ns_issue_vld);

  p_last_hold_r8: assert property (@(posedge clk) disable iff (rst)
    pop_cnt == '0 |=> $stable(last_seq));

  p_full_cnt_r10: assert property (@(posedge clk) disable iff (rst)
    pop_cnt == PW'(WIDTH) |=> full_cnt == $past(full_cnt) + CNT_W'(1));

  p_wait_hold_r9: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(ns_wait_cnt));
endmodule

bind rob_commit_head rch_checker #(
  .WIDTH(WIDTH), .SEQ_W(SEQ_W), .CNT_W(CNT_W), .PW(PW)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .stall        (stall),
  .head_valid   (head_valid),
  .head_done    (head_done),
  .head_nonspec (head_nonspec),
  .head_seq     (head_seq),
  .pop_cnt      (pop_cnt),
  .ns_issue_vld (ns_issue_vld),
  .ns_issue_seq (ns_issue_seq),
  .last_seq     (last_seq),
  .ns_wait_cnt  (ns_wait_cnt),
  .full_cnt     (full_cnt)
);

// File: tb/rob_commit_head_tb.sv
module rob_commit_head_tb;
  localparam int W       = 4;
  localparam int SW      = 16;
  localparam int CW      = 32;
  localparam int PW      = 3;
  localparam int CLK_PER = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stall = 1'b0;
  logic [W-1:0] hv = '0, hd = '0, hn = '0;
  logic [W*SW-1:0] hs = '0;
  logic [PW-1:0] pop_cnt;
  logic ns_issue_vld;
  logic [SW-1:0] ns_issue_seq, last_seq;
  logic [CW-1:0] ns_wait_cnt, full_cnt;

  int total = 0;
  int bad   = 0;

  // Expected registered state
  bit          e_iv = 0;
  logic [SW-1:0] e_is = '0, e_last = '0;
  logic [CW-1:0] e_wait = '0, e_full = '0;
  bit          m_sent = 0;
  logic [SW-1:0] m_sseq = '0;

  always #(CLK_PER/2) clk = ~clk;

  rob_commit_head #(.WIDTH(W), .SEQ_W(SW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .stall(stall),
    .head_valid(hv), .head_done(hd), .head_nonspec(hn), .head_seq(hs),
    .pop_cnt(pop_cnt), .ns_issue_vld(ns_issue_vld), .ns_issue_seq(ns_issue_seq),
    .last_seq(last_seq), .ns_wait_cnt(ns_wait_cnt), .full_cnt(full_cnt)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_pop(input logic [W-1:0] v, d, n, input bit st);
    int c = 0;
    if (st) return 0;
    for (int i = 0; i < W; i++) begin
      if (v[i] && d[i] && (i == 0 || !n[i])) c++;
      else break;
    end
    return c;
  endfunction

  task automatic check_regs();
    chk("R5 issue valid", 64'(ns_issue_vld), 64'(e_iv));
    if (e_iv) chk("R5 issue seq", 64'(ns_issue_seq), 64'(e_is));
    chk("R8 last seq", 64'(last_seq), 64'(e_last));
    chk("R9 wait count", 64'(ns_wait_cnt), 64'(e_wait));
    chk("R10 full count", 64'(full_cnt), 64'(e_full));
  endtask

  task automatic step(input logic [W-1:0] v, d, n, input logic [SW-1:0] base,
                      input bit st, input string tag);
    int ep;
    bit want, fire;
    @(negedge clk);
    check_regs();
    hv = v; hd = d; hn = n; stall = st;
    for (int i = 0; i < W; i++) hs[i*SW +: SW] = base + SW'(i);
    #1;
    ep = exp_pop(v, d, n, st);
    chk(st ? "R7 stall pop" : tag, 64'(pop_cnt), 64'(ep));
    want = !st && v[0] && n[0] && !d[0];
    fire = want && !(m_sent && m_sseq == base);
    e_iv = fire;
    if (fire) begin e_is = base; m_sent = 1; m_sseq = base; end
    else if (ep > 0) m_sent = 0;
    if (want) e_wait++;
    if (ep == W) e_full++;
    if (ep > 0) e_last = base + SW'(ep - 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [SW-1:0] base;
    logic [W-1:0] v, d, n;
    bit st;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset values visible while reset is held
    chk("R11 reset pop", 64'(pop_cnt), 0);
    check_regs();
    rst = 1'b0;

    step(4'b1111, 4'b1111, 4'b0000, 16'd10, 0, "R1 full window");
    step(4'b1111, 4'b1011, 4'b0000, 16'd20, 0, "R2 gap stops run");
    step(4'b0111, 4'b0111, 4'b0000, 16'd30, 0, "R2 invalid slot");
    step(4'b1111, 4'b1111, 4'b0100, 16'd40, 0, "R3 nonspec slot2");
    step(4'b1111, 4'b0110, 4'b0001, 16'd50, 0, "R5 nonspec waits");
    step(4'b1111, 4'b0110, 4'b0001, 16'd50, 0, "R6 same head");
    step(4'b1111, 4'b0110, 4'b0001, 16'd50, 1, "R7 stall");
    step(4'b1111, 4'b0110, 4'b0001, 16'd50, 0, "R6 same head again");
    step(4'b1111, 4'b0111, 4'b0001, 16'd50, 0, "R4 nonspec head retires");
    step(4'b1111, 4'b1111, 4'b0001, 16'd53, 0, "R4 nonspec head full");
    step(4'b1111, 4'b1110, 4'b0001, 16'd57, 0, "R5 new nonspec head");

    base = 16'd100;
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(2) == 0) base = base + SW'($urandom_range(1, 8));
      v = '0;
      for (int i = 0; i < W; i++) if (i < $urandom_range(W)) v[i] = 1'b1;
      d = '0; n = '0;
      for (int i = 0; i < W; i++) begin
        d[i] = ($urandom_range(3) != 0);
        n[i] = ($urandom_range(4) == 0);
      end
      st = ($urandom_range(9) == 0);
      step(v, d, n, base, st, "R1 random");
    end
    @(negedge clk);
    check_regs();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule